// File: doc/BRIEF.md
# CPU Bank Address Mapper

This block sits between an 8-bit CPU core and the memory system and turns each 16-bit CPU address into a 20-bit linear address. The CPU space is cut into eight 8 KB banks, selected by the top three address bits. Each bank is either translated or passed through. A translated bank adds an offset to the CPU address. The offset is shared by the lower four banks, and a second offset is shared by the upper four. A flag tells downstream chip-select logic whether the current address falls in a translated bank, so that ROM and I/O can be enabled only where no translation applies.

The configuration is loaded in one step from four 8-bit CPU register values when the core signals a mapping instruction. From that point interrupt requests to the core are held off until the core signals the end-of-mapping instruction. This leaves software time to set up its stack under the new layout. The block also contains the CPU's on-chip I/O port: a direction register and a data register. They sit at the two lowest CPU addresses whatever the mapping is, and accesses to them never reach linear memory.

Top module: `cpu_bank_mapper`

## Requirements
- R1: After reset every bank is pass-through, both offsets are zero, interrupts are not held off, and the port direction and data registers are zero (all port pins are inputs).
- R2: The bank index is cpu_addr[15:13]. Bits reg_x[7:4] enable translation for banks 0..3, with reg_x[4] controlling bank 0. Bits reg_z[7:4] enable translation for banks 4..7, with reg_z[4] controlling bank 4.
- R3: In a translated bank, lin_addr = cpu_addr + (offset << 8) modulo 2^20. Banks 0..3 use the offset {reg_x[3:0], reg_a}. Banks 4..7 use the offset {reg_z[3:0], reg_y}. lin_mapped is 1 in a translated bank, even when the offset is zero.
- R4: In a pass-through bank, lin_addr equals cpu_addr zero-extended to 20 bits, and lin_mapped is 0.
- R5: The configuration is captured only at a clock edge where map_stb is high. An access in the cycle that carries map_stb still uses the old configuration. Register values presented without map_stb have no effect.
- R6: After an edge with map_stb high, irq_out is forced low. It stays low until an edge with eom_stb high (and map_stb low), after which irq_out follows irq_in again. If both strobes are high at the same edge, the hold-off is set.
- R7: CPU addresses 0x0000 and 0x0001 select the I/O port in every mapping. For those addresses mem_en is 0. port_rdata returns the direction register at 0x0000 and the pin value at 0x0001. For any other address port_rdata is 0 and mem_en equals cpu_en.
- R8: A write (cpu_en and cpu_we high) to 0x0000 loads the direction register, and a write to 0x0001 loads the data register. port_pins_oe shows the direction register and port_pins_out shows the data register. A read of 0x0001 returns data bits where the direction bit is 1 and port_pins_in bits where it is 0. Writes to other addresses leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_stb | input | 1 | Mapping instruction strobe |
| eom_stb | input | 1 | End-of-mapping instruction strobe |
| reg_a | input | 8 | CPU register A value |
| reg_x | input | 8 | CPU register X value |
| reg_y | input | 8 | CPU register Y value |
| reg_z | input | 8 | CPU register Z value |
| cpu_en | input | 1 | CPU access valid this cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| irq_in | input | 1 | Interrupt request from the system |
| lin_addr | output | 20 | Translated linear address |
| lin_mapped | output | 1 | Current address lies in a translated bank |
| mem_en | output | 1 | Access forwarded to linear memory |
| port_rdata | output | 8 | I/O port read data |
| port_pins_in | input | 8 | I/O port pin input levels |
| port_pins_out | output | 8 | I/O port output data |
| port_pins_oe | output | 8 | I/O port per-pin output enable |
| irq_out | output | 1 | Interrupt request to the CPU core |

## Verification
A wrong enable bit or offset register shows up at once as a wrong lin_addr or lin_mapped, in the first cycle the CPU touches the affected bank. Bank-ordering slips, such as the wrong nibble or the wrong half, need vectors that touch both halves and single banks. A stuck or early-released hold-off is visible on irq_out one cycle after the strobe edge, while irq_in is held high. A wrong port register is visible on port_pins_oe and port_pins_out right after the write edge, and on the mixed read of address 0x0001.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    localparam int unsigned CPU_AW     = 16;
    localparam int unsigned LIN_AW     = 20;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned NUM_BANKS  = 8;
    localparam int unsigned BANK_BITS  = $clog2(NUM_BANKS);
    localparam int unsigned PAGE_SHIFT = 8;
    localparam int unsigned OFS_W      = LIN_AW - PAGE_SHIFT;
    localparam int unsigned HALF       = NUM_BANKS / 2;

    typedef struct packed {
        logic [NUM_BANKS-1:0] en;
        logic [OFS_W-1:0]     ofs_lo;
        logic [OFS_W-1:0]     ofs_hi;
        logic                 irq_hold;
    } map_state_t;

    typedef struct packed {
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] dat;
    } port_state_t;
endpackage

// File: rtl/cbm_map_regs.sv
module cbm_map_regs
    import cbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             map_stb,
    input  logic             eom_stb,
    input  logic [REG_W-1:0] reg_a,
    input  logic [REG_W-1:0] reg_x,
    input  logic [REG_W-1:0] reg_y,
    input  logic [REG_W-1:0] reg_z,
    output map_state_t       st_o
);
    localparam int unsigned NIB = REG_W / 2;

    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (map_stb) begin
            st_d.en       = {reg_z[REG_W-1:NIB], reg_x[REG_W-1:NIB]};
            st_d.ofs_lo   = {reg_x[NIB-1:0], reg_a};
            st_d.ofs_hi   = {reg_z[NIB-1:0], reg_y};
            st_d.irq_hold = 1'b1;
        end else if (eom_stb) begin
            st_d.irq_hold = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/cbm_translate.sv
module cbm_translate
    import cbm_pkg::*;
(
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [NUM_BANKS-1:0] en,
    input  logic [OFS_W-1:0]     ofs_lo,
    input  logic [OFS_W-1:0]     ofs_hi,
    output logic [LIN_AW-1:0]    lin_addr,
    output logic                 mapped
);
    logic [OFS_W-1:0]     bank_ofs [NUM_BANKS];
    logic [BANK_BITS-1:0] bank_idx;
    logic [LIN_AW-1:0]    ofs_sh;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (b < HALF) begin : g_lo
            assign bank_ofs[b] = ofs_lo;
        end else begin : g_hi
            assign bank_ofs[b] = ofs_hi;
        end
    end

    assign bank_idx = cpu_addr[CPU_AW-1 -: BANK_BITS];
    assign mapped   = en[bank_idx];
    assign ofs_sh   = {bank_ofs[bank_idx], {PAGE_SHIFT{1'b0}}};

    always_comb begin
        if (mapped) lin_addr = LIN_AW'(cpu_addr) + ofs_sh;
        else        lin_addr = LIN_AW'(cpu_addr);
    end
endmodule

// File: rtl/cbm_io_port.sv
module cbm_io_port
    import cbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             reg_sel,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] pins_in,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] pins_out,
    output logic [REG_W-1:0] pins_oe
);
    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel && wr) begin
            if (reg_sel) st_d.dat = wdata;
            else         st_d.dir = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!sel)        rdata = '0;
        else if (reg_sel) rdata = (st_q.dat & st_q.dir) | (pins_in & ~st_q.dir);
        else              rdata = st_q.dir;
    end

    assign pins_out = st_q.dat;
    assign pins_oe  = st_q.dir;
endmodule

// File: rtl/cpu_bank_mapper.sv
module cpu_bank_mapper
    import cbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_stb,
    input  logic              eom_stb,
    input  logic [REG_W-1:0]  reg_a,
    input  logic [REG_W-1:0]  reg_x,
    input  logic [REG_W-1:0]  reg_y,
    input  logic [REG_W-1:0]  reg_z,
    input  logic              cpu_en,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [REG_W-1:0]  cpu_wdata,
    input  logic              irq_in,
    output logic [LIN_AW-1:0] lin_addr,
    output logic              lin_mapped,
    output logic              mem_en,
    output logic [REG_W-1:0]  port_rdata,
    input  logic [REG_W-1:0]  port_pins_in,
    output logic [REG_W-1:0]  port_pins_out,
    output logic [REG_W-1:0]  port_pins_oe,
    output logic              irq_out
);
    map_state_t cfg;
    logic       port_hit;

    cbm_map_regs u_regs (
        .clk(clk), .rst_n(rst_n), .map_stb(map_stb), .eom_stb(eom_stb),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_z(reg_z),
        .st_o(cfg)
    );

    cbm_translate u_xlat (
        .cpu_addr(cpu_addr), .en(cfg.en), .ofs_lo(cfg.ofs_lo),
        .ofs_hi(cfg.ofs_hi), .lin_addr(lin_addr), .mapped(lin_mapped)
    );

    // Port decode uses the raw CPU address, never the translated one.
    assign port_hit = (cpu_addr[CPU_AW-1:1] == '0);

    cbm_io_port u_port (
        .clk(clk), .rst_n(rst_n), .sel(port_hit), .reg_sel(cpu_addr[0]),
        .wr(cpu_en && cpu_we), .wdata(cpu_wdata), .pins_in(port_pins_in),
        .rdata(port_rdata), .pins_out(port_pins_out), .pins_oe(port_pins_oe)
    );

    assign mem_en  = cpu_en && !port_hit;
    assign irq_out = irq_in && !cfg.irq_hold;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker
    import cbm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              map_stb,
    input logic              eom_stb,
    input logic              cpu_en,
    input logic              cpu_we,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [REG_W-1:0]  cpu_wdata,
    input logic              irq_in,
    input logic [LIN_AW-1:0] lin_addr,
    input logic              lin_mapped,
    input logic              mem_en,
    input logic [REG_W-1:0]  port_pins_oe,
    input logic [REG_W-1:0]  port_pins_out,
    input logic              irq_out
);
    p_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (port_pins_oe == '0 && port_pins_out == '0 && !lin_mapped));

    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lin_mapped |-> lin_addr == LIN_AW'(cpu_addr));

    p_hold_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(map_stb) && $stable(cpu_addr)) |-> ($stable(lin_addr) && $stable(lin_mapped)));

    p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        map_stb |=> !irq_out);

    p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eom_stb && !map_stb) |=> (irq_out == irq_in));

    p_port_iso_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && cpu_addr[CPU_AW-1:1] == '0) |-> !mem_en);

    p_dir_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && cpu_we && cpu_addr == '0) |=> port_pins_oe == $past(cpu_wdata));

    p_dat_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_en && cpu_we && cpu_addr == CPU_AW'(1)) |=> port_pins_out == $past(cpu_wdata));
endmodule

bind cpu_bank_mapper cbm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .map_stb(map_stb), .eom_stb(eom_stb),
    .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .irq_in(irq_in), .lin_addr(lin_addr), .lin_mapped(lin_mapped), .mem_en(mem_en),
    .port_pins_oe(port_pins_oe), .port_pins_out(port_pins_out), .irq_out(irq_out)
);

// File: tb/cpu_bank_mapper_tb.sv
module cpu_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_stb = 0, eom_stb = 0, cpu_en = 0, cpu_we = 0, irq_in = 0;
    logic [7:0]  reg_a = 0, reg_x = 0, reg_y = 0, reg_z = 0, cpu_wdata = 0, port_pins_in = 0;
    logic [15:0] cpu_addr = 0;
    logic [19:0] lin_addr;
    logic        lin_mapped, mem_en, irq_out;
    logic [7:0]  port_rdata, port_pins_out, port_pins_oe;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    cpu_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .map_stb(map_stb), .eom_stb(eom_stb),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_z(reg_z),
        .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .irq_in(irq_in), .lin_addr(lin_addr), .lin_mapped(lin_mapped), .mem_en(mem_en),
        .port_rdata(port_rdata), .port_pins_in(port_pins_in), .port_pins_out(port_pins_out),
        .port_pins_oe(port_pins_oe), .irq_out(irq_out)
    );

    // {a, x, y, z, cpu_addr, expected lin_addr, expected mapped}
    localparam int NV = 6;
    localparam logic [68:0] VEC [NV] = '{
        {8'h12, 8'h13, 8'h00, 8'h00, 16'h0100, 20'h31300, 1'b1},
        {8'h12, 8'h13, 8'h00, 8'h00, 16'h2000, 20'h02000, 1'b0},
        {8'hFF, 8'hFF, 8'h00, 8'h00, 16'h7FFF, 20'h07EFF, 1'b1},
        {8'h00, 8'h00, 8'h40, 8'h85, 16'hE123, 20'h62123, 1'b1},
        {8'h00, 8'h00, 8'h40, 8'h85, 16'hC000, 20'h0C000, 1'b0},
        {8'h00, 8'h00, 8'h00, 8'h10, 16'h8005, 20'h08005, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_map(input logic [7:0] a, x, y, z);
        @(negedge clk);
        reg_a = a; reg_x = x; reg_y = y; reg_z = z; map_stb = 1;
        @(negedge clk);
        map_stb = 0;
    endtask

    task automatic do_write(input logic [15:0] ad, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = ad; cpu_wdata = d; cpu_en = 1; cpu_we = 1;
        @(negedge clk);
        cpu_we = 0;
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        irq_in = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        cpu_addr = 16'h4000; reg_a = 8'hFF; reg_x = 8'hFF; #1;
        chk("R1 lin", lin_addr, 20'h04000);
        chk("R1 mapped", lin_mapped, 0);
        chk("R1 oe", port_pins_oe, 0);
        chk("R1 out", port_pins_out, 0);
        chk("R1 irq", irq_out, 1);
        cpu_addr = 16'hE000; #1;
        chk("R1 hi lin", lin_addr, 20'h0E000);

        // R2/R3/R4 table walk
        for (int i = 0; i < NV; i++) begin
            do_map(VEC[i][68:61], VEC[i][60:53], VEC[i][52:45], VEC[i][44:37]);
            cpu_addr = VEC[i][36:21]; cpu_en = 1; #1;
            chk("R3 lin", lin_addr, VEC[i][20:1]);
            chk("R2 mapped", lin_mapped, VEC[i][0]);
        end

        // R6: held after map, released by eom
        @(negedge clk); #1;
        chk("R6 held", irq_out, 0);
        @(negedge clk); eom_stb = 1; #1;
        chk("R6 held in eom cycle", irq_out, 0);
        @(negedge clk); eom_stb = 0; #1;
        chk("R6 released", irq_out, 1);
        @(negedge clk); eom_stb = 1; map_stb = 1;
        @(negedge clk); eom_stb = 0; map_stb = 0; #1;
        chk("R6 both strobes hold", irq_out, 0);
        @(negedge clk); eom_stb = 1;
        @(negedge clk); eom_stb = 0; #1;
        chk("R6 released again", irq_out, 1);

        // R5: old mapping in strobe cycle, no load without strobe
        do_map(8'h00, 8'h10, 8'h00, 8'h00);
        cpu_addr = 16'h0200; #1;
        chk("R5 base", lin_addr, 20'h00200);
        @(negedge clk);
        reg_a = 8'h05; map_stb = 1; #1;
        chk("R5 old in strobe cycle", lin_addr, 20'h00200);
        @(negedge clk); map_stb = 0; #1;
        chk("R5 new after edge", lin_addr, 20'h00700);
        reg_a = 8'h77; reg_x = 8'h00;
        repeat (2) @(negedge clk); #1;
        chk("R5 no strobe no change", lin_addr, 20'h00700);
        chk("R5 still mapped", lin_mapped, 1);

        // R7/R8: I/O port under a mapping of bank 0
        cpu_en = 1; cpu_addr = 16'h0000; #1;
        chk("R7 no mem at 0", mem_en, 0);
        cpu_addr = 16'h0001; #1;
        chk("R7 no mem at 1", mem_en, 0);
        do_write(16'h0000, 8'h0F);
        #1 chk("R8 dir", port_pins_oe, 8'h0F);
        do_write(16'h0001, 8'hA5);
        #1 chk("R8 data", port_pins_out, 8'hA5);
        port_pins_in = 8'h3C; cpu_addr = 16'h0001; #1;
        chk("R8 mixed read", port_rdata, 8'h35);
        cpu_addr = 16'h0000; #1;
        chk("R7 dir read", port_rdata, 8'h0F);
        do_write(16'h0002, 8'hFF);
        #1 chk("R8 other addr dir", port_pins_oe, 8'h0F);
        chk("R8 other addr data", port_pins_out, 8'hA5);
        cpu_addr = 16'h0002; #1;
        chk("R7 mem at 2", mem_en, 1);
        chk("R7 rdata at 2", port_rdata, 0);
        chk("R7 lin at 2", lin_addr, 20'h00502);
        cpu_en = 0; #1;
        chk("R7 mem follows en", mem_en, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule